// File: doc/BRIEF.md
# Paged Timing-Event Code Filter

This block sits behind an event-link decoder and receives one 8-bit timing-event code per clock when a code is present. It looks each code up in an on-chip table. The table is split into eight pages, one for each machine user. Only one page is live at a time. The entry for a code decides two things: whether the code is forwarded to the local processor, and whether it switches the live page. No code value has a fixed meaning. Any value can be an ordinary event, a fiducial or a user-change marker, depending only on what is written into the table.

Each forwarded code is pushed into a 16-entry queue together with a free-running microsecond time stamp. An interrupt stays high while the queue holds anything. The processor reads entries from the queue head. It can rewrite any table entry through a write port, and the normal practice is to edit a page that is not live. It can also arm a page request, which overrides the page named in the table the next time a user-change code is processed. Arrivals are never stalled. If the queue is full and nothing is popped, the new event is dropped and a sticky flag records the loss.

Two small state machines control the block. The page controller has the states `PG_IDLE` and `PG_ARMED`. It moves from `PG_IDLE` to `PG_ARMED` on an arm request ("arm"). It moves from `PG_ARMED` back to `PG_IDLE` when a user-change code consumes the request ("consume"). An arm request in `PG_ARMED` replaces the held page ("re-arm"). The queue controller has the states `FQ_EMPTY`, `FQ_PART` and `FQ_FULL`. It moves from `FQ_EMPTY` to `FQ_PART` on the first accepted push ("first"), from `FQ_PART` to `FQ_FULL` when a push fills the last slot ("fill"), from `FQ_FULL` to `FQ_PART` when a pop frees a slot ("drain"), and from `FQ_PART` to `FQ_EMPTY` when the last entry is popped ("last").

Top module: `evt_code_filter`

## Requirements
- R1: After reset the live page is 0, the queue is empty, the interrupt and the overflow flag are low, and every table entry is zero, so no code is forwarded.
- R2: A table entry is 5 bits. Bit 0 marks the code as forwarded, bit 1 marks it as user-change, and bits 4:2 give the page number that a user-change code selects. A write to an entry is visible to lookups from the next cycle on. A lookup in the same cycle as a write to that entry sees the old value.
- R3: A code whose live-page entry has bit 0 set is stored in the queue with its value at the clock edge where it is presented. One code per cycle is accepted back to back without stalling. Codes with bit 0 clear are not stored.
- R4: A code whose live-page entry has bit 1 set changes the live page at the edge that processes it. A code presented in the next cycle is looked up in the new page. Whether the user-change code itself is stored is decided by its entry in the old page. Without a user-change code, the live page never changes.
- R5: When a page request is armed, the next user-change code selects the armed page instead of the table field and consumes the request. An arm request presented in the same cycle as a user-change code is kept for the following switch.
- R6: The time-stamp counter is 0 after reset and increments once every TICK_DIV clocks (100 by default, i.e. 1 µs at 100 MHz). A stored entry carries the counter value of the cycle in which its code was presented.
- R7: The queue is first-in first-out. The oldest entry's code and stamp are shown on the read outputs while the queue is not empty. A pop removes that entry. A pop while the queue is empty has no effect.
- R8: The interrupt is high exactly while the queue holds at least one entry. It falls in the cycle after the last entry is popped.
- R9: A forwarded code that arrives while the queue is full with no pop is dropped and sets the sticky overflow flag. A push and a pop in the same cycle at full are both accepted. The flag clears on the clear input, and a new overflow in the same cycle wins over the clear.
- R10: The level output gives the number of stored entries, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event code is present this cycle |
| ev_code | input | 8 | Event code value |
| tw_en | input | 1 | Table write strobe |
| tw_page | input | 3 | Page to write |
| tw_code | input | 8 | Code entry to write |
| tw_entry | input | 5 | Entry value: bit 0 forward, bit 1 user-change, bits 4:2 next page |
| arm_valid | input | 1 | Arm a page request |
| arm_page | input | 3 | Page to arm |
| rd_pop | input | 1 | Remove the queue head |
| ovf_clear | input | 1 | Clear the overflow flag |
| cur_page | output | 3 | Live page number |
| irq | output | 1 | Queue holds data |
| rd_code | output | 8 | Code at the queue head |
| rd_stamp | output | 32 | Time stamp at the queue head |
| fifo_level | output | 5 | Number of stored entries |
| overflow | output | 1 | Sticky lost-event flag |

## Verification
The collisions that matter most are a forwarded push and a processor pop arriving together while the queue is full, and a user-change code coinciding with an arm request or a table write to the entry being looked up. The bench fills the queue with back-to-back forwarded codes and then presents push with pop, push without pop, and overflow with clear in the same cycle. It also presents a switch together with an arm, and a write together with a lookup of the same entry. A reference model applies each rule in the stated order, and every cycle it compares the level, interrupt, flag, page and head entry. A long random phase with dense codes and a partial pop rate makes the same collisions happen many more times.

// File: rtl/evt_filt_pkg.sv
package evt_filt_pkg;

    // Bit positions inside one table entry
    localparam int ENT_FWD_BIT  = 0;
    localparam int ENT_UCHG_BIT = 1;
    localparam int ENT_PG_LSB   = 2;

    typedef enum logic [0:0] {
        PG_IDLE  = 1'b0,
        PG_ARMED = 1'b1
    } pg_state_e;

    typedef enum logic [1:0] {
        FQ_EMPTY = 2'd0,
        FQ_PART  = 2'd1,
        FQ_FULL  = 2'd2
    } fq_state_e;

endpackage

// File: rtl/efl_code_table.sv
module efl_code_table #(
    parameter int CODE_W = 8,
    parameter int PAGES  = 8,
    localparam int PAGE_W  = $clog2(PAGES),
    localparam int ENTRY_W = PAGE_W + 2,
    localparam int NUM_ENT = PAGES << CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic [PAGE_W-1:0]  rd_page,
    input  logic [CODE_W-1:0]  rd_code,
    output logic [ENTRY_W-1:0] rd_entry
);

    logic [ENTRY_W-1:0] mem [NUM_ENT];

    // Write lands at the edge; lookup is combinational on the live page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[{wr_page, wr_code}] <= wr_entry;
        end
    end

    always_comb begin
        rd_entry = mem[{rd_page, rd_code}];
    end

endmodule

// File: rtl/efl_stamp_ctr.sv
module efl_stamp_ctr #(
    parameter int STAMP_W  = 32,
    parameter int TICK_DIV = 100,
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STAMP_W-1:0] stamp
);

    logic [PRE_W-1:0] pre;
    logic             tick;

    generate
        if (TICK_DIV > 1) begin : g_div
            assign tick = (pre == PRE_W'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre   <= '0;
            stamp <= '0;
        end else if (tick) begin
            pre   <= '0;
            stamp <= stamp + STAMP_W'(1);
        end else begin
            pre   <= pre + PRE_W'(1);
        end
    end

endmodule

// File: rtl/efl_page_ctl.sv
module efl_page_ctl
    import evt_filt_pkg::*;
#(
    parameter int PAGES = 8,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uchg_hit,
    input  logic [PAGE_W-1:0] entry_page,
    input  logic              arm_valid,
    input  logic [PAGE_W-1:0] arm_page,
    output logic [PAGE_W-1:0] cur_page
);

    pg_state_e         st_q, st_d;
    logic [PAGE_W-1:0] page_d;
    logic [PAGE_W-1:0] pend_q, pend_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= PG_IDLE;
            cur_page <= '0;
            pend_q   <= '0;
        end else begin
            st_q     <= st_d;
            cur_page <= page_d;
            pend_q   <= pend_d;
        end
    end

    // Next state and page selection
    always_comb begin
        st_d   = st_q;
        page_d = cur_page;
        pend_d = pend_q;
        unique case (st_q)
            PG_IDLE: begin
                if (uchg_hit) begin
                    page_d = entry_page;
                end
            end
            PG_ARMED: begin
                if (uchg_hit) begin
                    page_d = pend_q;     // consume
                    st_d   = PG_IDLE;
                end
            end
            default: st_d = PG_IDLE;
        endcase
        // arm / re-arm; a request in a switch cycle waits for the next switch
        if (arm_valid) begin
            st_d   = PG_ARMED;
            pend_d = arm_page;
        end
    end

endmodule

// File: rtl/efl_event_fifo.sv
module efl_event_fifo
    import evt_filt_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              ovf_clear,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              not_empty,
    output logic              ovf
);

    fq_state_e         st_q, st_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop, ovf_set;
    logic [LVL_W-1:0]  level_d;

    always_comb begin
        do_pop  = pop && (st_q != FQ_EMPTY);
        do_push = push && ((st_q != FQ_FULL) || do_pop);
        ovf_set = push && (st_q == FQ_FULL) && !pop;
        level_d = level + LVL_W'(do_push) - LVL_W'(do_pop);
    end

    // State register and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FQ_EMPTY;
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            st_q  <= st_d;
            level <= level_d;
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            if (ovf_set) begin
                ovf <= 1'b1;
            end else if (ovf_clear) begin
                ovf <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FQ_EMPTY: begin
                if (do_push) begin
                    st_d = (DEPTH == 1) ? FQ_FULL : FQ_PART;        // first
                end
            end
            FQ_PART: begin
                if (do_push && !do_pop && level == LVL_W'(DEPTH - 1)) begin
                    st_d = FQ_FULL;                                 // fill
                end else if (do_pop && !do_push && level == LVL_W'(1)) begin
                    st_d = FQ_EMPTY;                                // last
                end
            end
            FQ_FULL: begin
                if (do_pop && !do_push) begin
                    st_d = (DEPTH == 1) ? FQ_EMPTY : FQ_PART;       // drain
                end
            end
            default: st_d = FQ_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        not_empty = (st_q != FQ_EMPTY);
        head      = mem[rd_ptr];
    end

endmodule

// File: rtl/evt_code_filter.sv
module evt_code_filter
    import evt_filt_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int PAGES    = 8,
    parameter int DEPTH    = 16,
    parameter int STAMP_W  = 32,
    parameter int TICK_DIV = 100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_valid,
    input  logic [CODE_W-1:0]          ev_code,
    input  logic                       tw_en,
    input  logic [$clog2(PAGES)-1:0]   tw_page,
    input  logic [CODE_W-1:0]          tw_code,
    input  logic [$clog2(PAGES)+1:0]   tw_entry,
    input  logic                       arm_valid,
    input  logic [$clog2(PAGES)-1:0]   arm_page,
    input  logic                       rd_pop,
    input  logic                       ovf_clear,
    output logic [$clog2(PAGES)-1:0]   cur_page,
    output logic                       irq,
    output logic [CODE_W-1:0]          rd_code,
    output logic [STAMP_W-1:0]         rd_stamp,
    output logic [$clog2(DEPTH):0]     fifo_level,
    output logic                       overflow
);

    localparam int PAGE_W  = $clog2(PAGES);
    localparam int ENTRY_W = PAGE_W + 2;
    localparam int DATA_W  = CODE_W + STAMP_W;

    logic [ENTRY_W-1:0] entry;
    logic               act_hit;
    logic               uc_hit;
    logic [PAGE_W-1:0]  entry_page;
    logic [STAMP_W-1:0] stamp_now;
    logic [DATA_W-1:0]  head;

    efl_code_table #(.CODE_W(CODE_W), .PAGES(PAGES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tw_en),
        .wr_page  (tw_page),
        .wr_code  (tw_code),
        .wr_entry (tw_entry),
        .rd_page  (cur_page),
        .rd_code  (ev_code),
        .rd_entry (entry)
    );

    always_comb begin
        act_hit    = ev_valid && entry[ENT_FWD_BIT];
        uc_hit     = ev_valid && entry[ENT_UCHG_BIT];
        entry_page = entry[ENT_PG_LSB +: PAGE_W];
    end

    efl_stamp_ctr #(.STAMP_W(STAMP_W), .TICK_DIV(TICK_DIV)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .stamp (stamp_now)
    );

    efl_page_ctl #(.PAGES(PAGES)) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .uchg_hit   (uc_hit),
        .entry_page (entry_page),
        .arm_valid  (arm_valid),
        .arm_page   (arm_page),
        .cur_page   (cur_page)
    );

    efl_event_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (act_hit),
        .push_data ({ev_code, stamp_now}),
        .pop       (rd_pop),
        .ovf_clear (ovf_clear),
        .head      (head),
        .level     (fifo_level),
        .not_empty (irq),
        .ovf       (overflow)
    );

    always_comb begin
        rd_code  = head[DATA_W-1 -: CODE_W];
        rd_stamp = head[STAMP_W-1:0];
    end

endmodule

// File: rtl/evt_code_filter_chk.sv
module evt_code_filter_chk #(
    parameter int DEPTH   = 16,
    parameter int PAGE_W  = 3,
    parameter int STAMP_W = 32,
    localparam int LVL_W  = $clog2(DEPTH) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic [LVL_W-1:0]   fifo_level,
    input logic               overflow,
    input logic               ovf_clear,
    input logic               rd_pop,
    input logic [PAGE_W-1:0]  cur_page,
    input logic               act_hit,
    input logic               uc_hit,
    input logic [STAMP_W-1:0] stamp_now
);

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (fifo_level != '0));

    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH) && act_hit && !rd_pop) |=> overflow);

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clear) |=> overflow);

    // R9
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH) && act_hit && rd_pop) |=> (fifo_level == LVL_W'(DEPTH)));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uc_hit |=> $stable(cur_page));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_hit && !rd_pop) |=> $stable(fifo_level));

    // R6
    stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_now == $past(stamp_now)) || (stamp_now == $past(stamp_now) + STAMP_W'(1)));

endmodule

bind evt_code_filter evt_code_filter_chk #(
    .DEPTH   (DEPTH),
    .PAGE_W  ($clog2(PAGES)),
    .STAMP_W (STAMP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .fifo_level (fifo_level),
    .overflow   (overflow),
    .ovf_clear  (ovf_clear),
    .rd_pop     (rd_pop),
    .cur_page   (cur_page),
    .act_hit    (act_hit),
    .uc_hit     (uc_hit),
    .stamp_now  (stamp_now)
);

// File: tb/evt_code_filter_tb.sv
module evt_code_filter_tb;

    localparam int TICK = 100;
    localparam int QD   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic        tw_en = 1'b0;
    logic [2:0]  tw_page = '0;
    logic [7:0]  tw_code = '0;
    logic [4:0]  tw_entry = '0;
    logic        arm_valid = 1'b0;
    logic [2:0]  arm_page = '0;
    logic        rd_pop = 1'b0;
    logic        ovf_clear = 1'b0;
    logic [2:0]  cur_page;
    logic        irq;
    logic [7:0]  rd_code;
    logic [31:0] rd_stamp;
    logic [4:0]  fifo_level;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int unsigned tick_cnt = 0;

    // reference model state
    logic [4:0]  m_tbl [8][256];
    int          m_page;
    bit          m_armed;
    int          m_pend;
    logic [39:0] m_q [$];
    bit          m_ovf;

    evt_code_filter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_code    (ev_code),
        .tw_en      (tw_en),
        .tw_page    (tw_page),
        .tw_code    (tw_code),
        .tw_entry   (tw_entry),
        .arm_valid  (arm_valid),
        .arm_page   (arm_page),
        .rd_pop     (rd_pop),
        .ovf_clear  (ovf_clear),
        .cur_page   (cur_page),
        .irq        (irq),
        .rd_code    (rd_code),
        .rd_stamp   (rd_stamp),
        .fifo_level (fifo_level),
        .overflow   (overflow)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) tick_cnt <= tick_cnt + 1;
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R10 level", 40'(fifo_level), 40'(m_q.size()));
        chk("R8 irq", 40'(irq), 40'(m_q.size() != 0));
        chk("R9 overflow", 40'(overflow), 40'(m_ovf));
        chk("R4 page", 40'(cur_page), 40'(m_page));
        if (m_q.size() != 0) begin
            chk("R3 head code", 40'(rd_code), 40'(m_q[0][39:32]));
            chk("R6 head stamp", 40'(rd_stamp), 40'(m_q[0][31:0]));
        end
    endtask

    // One cycle: model from present inputs, clock, return inputs to idle, compare
    task automatic cyc();
        logic [4:0] ent;
        bit hit_a, hit_u, full;
        ent   = m_tbl[m_page][ev_code];
        hit_a = ev_valid && ent[0];
        hit_u = ev_valid && ent[1];
        full  = (m_q.size() == QD);
        if (rd_pop && m_q.size() != 0) void'(m_q.pop_front());
        if (hit_a && (!full || rd_pop)) m_q.push_back({ev_code, 32'(tick_cnt / TICK)});
        if (hit_a && full && !rd_pop) m_ovf = 1'b1;
        else if (ovf_clear) m_ovf = 1'b0;
        if (tw_en) m_tbl[tw_page][tw_code] = tw_entry;
        if (hit_u) begin
            m_page  = m_armed ? m_pend : int'(ent[4:2]);
            m_armed = 1'b0;
        end
        if (arm_valid) begin
            m_armed = 1'b1;
            m_pend  = int'(arm_page);
        end
        @(posedge clk);
        @(negedge clk);
        ev_valid = 0; tw_en = 0; arm_valid = 0; rd_pop = 0; ovf_clear = 0;
        check_all();
    endtask

    task automatic wr(input int pg, input int code, input int val);
        tw_en = 1; tw_page = 3'(pg); tw_code = 8'(code); tw_entry = 5'(val);
        cyc();
    endtask

    task automatic ev(input int code);
        ev_valid = 1; ev_code = 8'(code);
        cyc();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h0005EED1);
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 256; c++) m_tbl[p][c] = '0;
        m_page = 0; m_armed = 0; m_pend = 0; m_ovf = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 page", 40'(cur_page), 40'd0);
        chk("R1 level", 40'(fifo_level), 40'd0);
        chk("R1 irq", 40'(irq), 40'd0);
        chk("R1 overflow", 40'(overflow), 40'd0);
        ev(8'h10);
        chk("R1 no entry forwarded", 40'(fifo_level), 40'd0);

        // R2: write and lookup of the same entry in one cycle sees old value
        tw_en = 1; tw_page = 0; tw_code = 8'h10; tw_entry = 5'b000_01;
        ev_valid = 1; ev_code = 8'h10;
        cyc();
        chk("R2 same-cycle write not seen", 40'(fifo_level), 40'd0);
        ev(8'h10);
        chk("R2 write seen next cycle", 40'(fifo_level), 40'd1);

        // R4: user-change code to page 2, next code uses new page
        wr(0, 8'hF0, {3'd2, 2'b10});
        wr(2, 8'h20, {3'd0, 2'b11});
        wr(2, 8'h21, 5'b000_01);
        ev(8'hF0);
        chk("R4 switched to 2", 40'(cur_page), 40'd2);
        chk("R4 uchg not forwarded", 40'(fifo_level), 40'd1);
        ev(8'h10);
        chk("R4 old-page code dropped", 40'(fifo_level), 40'd1);
        ev(8'h21);
        chk("R3 back-to-back stored", 40'(fifo_level), 40'd2);

        // R5: arm page 5, switch code names page 0 but armed wins; code stored
        arm_valid = 1; arm_page = 3'd5;
        cyc();
        ev(8'h20);
        chk("R5 armed page wins", 40'(cur_page), 40'd5);
        chk("R4 uchg stored by old entry", 40'(fifo_level), 40'd3);

        // R5: arm in the same cycle as a switch is held for the next switch
        wr(5, 8'h55, {3'd1, 2'b10});
        wr(3, 8'h55, {3'd6, 2'b10});
        arm_valid = 1; arm_page = 3'd3; ev_valid = 1; ev_code = 8'h55;
        cyc();
        chk("R5 table field used", 40'(cur_page), 40'd1);
        wr(1, 8'h55, {3'd7, 2'b10});
        ev(8'h55);
        chk("R5 held arm applied", 40'(cur_page), 40'd3);

        // R7: drain, then pop on empty is ignored
        while (fifo_level != 0) begin rd_pop = 1; cyc(); end
        chk("R8 irq low after drain", 40'(irq), 40'd0);
        rd_pop = 1; cyc();
        chk("R7 pop on empty", 40'(fifo_level), 40'd0);

        // R9: fill back to back, push+pop at full, overflow, clear
        wr(3, 8'h33, 5'b000_01);
        for (int i = 0; i < QD; i++) ev(8'h33);
        chk("R10 full", 40'(fifo_level), 40'(QD));
        ev_valid = 1; ev_code = 8'h33; rd_pop = 1; cyc();
        chk("R9 push+pop at full", 40'(overflow), 40'd0);
        ev_valid = 1; ev_code = 8'h33; ovf_clear = 1; cyc();
        chk("R9 set wins over clear", 40'(overflow), 40'd1);
        ovf_clear = 1; cyc();
        chk("R9 cleared", 40'(overflow), 40'd0);
        while (fifo_level != 0) begin rd_pop = 1; cyc(); end

        // Random phase with dense codes
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 99) < 25) begin
                tw_en = 1; tw_page = 3'($urandom_range(0, 7));
                tw_code = 8'($urandom_range(0, 15)); tw_entry = 5'($urandom);
            end
            if ($urandom_range(0, 99) < 70) begin
                ev_valid = 1; ev_code = 8'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 99) < 5) begin
                arm_valid = 1; arm_page = 3'($urandom_range(0, 7));
            end
            rd_pop    = ($urandom_range(0, 99) < 35);
            ovf_clear = ($urandom_range(0, 99) < 4);
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule